// File: doc/BRIEF.md
# Pixel Stipple, Fill and Copy Engine

This block speeds up drawing into an 8-bit-per-pixel frame memory. Software writes 32-bit words into one of two command windows, selected by `cmd_sel`. Each write is either a colour load or an operation trigger, depending on one bit of the write address. The address also carries the destination pixel. The engine then walks the pixel run one pixel per step and drives a single-port memory master.

The stipple window paints the stored colour through a 32-bit mask. The blit window copies a run of up to 32 pixels from a source pixel address. A reserved all-ones source value turns the copy into a solid fill with the stored colour.

A write that arrives while an operation runs is held off by the `cmd_valid`/`cmd_ready` handshake and is never lost. Reads from either window complete at once and return zero.

Top module: `pix_accel_engine`

## Requirements
- R1: An accepted write with `cmd_addr[2]` = 0 stores `cmd_wdata` as the colour and touches no memory. Every pixel painted afterwards by stipple or fill is `colour[7:0]`.
- R2: An accepted write with `cmd_addr[2]` = 1 starts an operation whose first destination pixel is `cmd_addr[22:3]`. Bits 1:0 of the address are ignored.
- R3: In stipple mode (`cmd_sel` = 0), mask bit 31-i controls pixel dest+i. A set bit writes the colour there. A clear bit issues no memory access.
- R4: A stipple operation keeps `busy` high for exactly 32 cycles after the accepting edge, whatever the mask.
- R5: In blit mode (`cmd_sel` = 1), `cmd_wdata[23:0]` is the source pixel and `cmd_wdata[28:24]` is the run length minus one. Bits 31:29 are ignored. A copy reads source+i and then writes dest+i for i in ascending order. Each pixel takes a read cycle followed at once by a write cycle, so `busy` lasts 2·len cycles.
- R6: A blit with source 0xFFFFFF fills dest..dest+len-1 with the colour, one write per cycle, and `busy` lasts len cycles.
- R7: A read (`cmd_we` = 0) is accepted when ready and returns `cmd_rdata` = 0. It changes neither memory nor the stored colour.
- R8: `cmd_ready` is low whenever `busy` is high. A write presented during an operation is accepted after it ends and then takes effect.
- R9: The memory master is idle while `busy` is low. Write cycles on back-to-back clocks go to consecutive addresses with the same data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command write/read request |
| cmd_ready | output | 1 | Engine can accept a command |
| cmd_we | input | 1 | 1 = write, 0 = read |
| cmd_sel | input | 1 | Window: 0 = stipple, 1 = blit |
| cmd_addr | input | 23 | Byte offset within the window |
| cmd_wdata | input | 32 | Command data word |
| cmd_rdata | output | 32 | Read data, always zero |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 20 | Pixel address |
| mem_wdata | output | 8 | Pixel write data |
| mem_rdata | input | 8 | Read data, valid the cycle after a read |

## Verification
The bound checker watches every cycle for the following:
- the handshake stays closed while busy;
- the memory stays quiet while idle;
- each copy read is followed directly by its write;
- back-to-back writes advance by one address with unchanged data;
- stipple runs last exactly 32 cycles.

Only the bench scenarios can show which pixels end up holding which values. Its reference memory model covers mask-selected pixels, overlapping ascending copies, fills against copies, and the colour seen by operations that were stalled behind a running one.

// File: rtl/pix_accel_pkg.sv
package pix_accel_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_STIP,
      SQ_FILL,
      SQ_CRD,
      SQ_CWR
   } seq_state_e;

   typedef enum logic [1:0] {
      OP_STIP,
      OP_FILL,
      OP_COPY
   } op_kind_e;

endpackage

// File: rtl/pix_accel_decode.sv
module pix_accel_decode
   import pix_accel_pkg::*;
#(
   parameter int APER_AW = 23,
   parameter int DATA_W  = 32,
   parameter int PIX_AW  = 20,
   parameter int SRC_W   = 24,
   parameter int LEN_W   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc,
   input  logic              cmd_we,
   input  logic              cmd_sel,
   input  logic [APER_AW-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   output logic [DATA_W-1:0] colour,
   output logic              go,
   output op_kind_e          kind,
   output logic [PIX_AW-1:0] dst,
   output logic [SRC_W-1:0]  src,
   output logic [LEN_W-1:0]  len_m1,
   output logic [DATA_W-1:0] mask
);
   localparam int GO_BIT  = 2;
   localparam int DST_LSB = 3;
   localparam logic [SRC_W-1:0] FILL_CODE = {SRC_W{1'b1}};

   logic trig;
   assign trig = cmd_addr[GO_BIT];

   // colour latch: only non-trigger writes load it
   always_ff @(posedge clk) begin
      if (!rst_n)
         colour <= '0;
      else if (acc && cmd_we && !trig)
         colour <= cmd_wdata;
   end

   assign go     = acc && cmd_we && trig;
   assign dst    = cmd_addr[DST_LSB +: PIX_AW];
   assign src    = cmd_wdata[SRC_W-1:0];
   assign len_m1 = cmd_wdata[SRC_W +: LEN_W];
   assign mask   = cmd_wdata;

   always_comb begin
      if (!cmd_sel)
         kind = OP_STIP;
      else if (src == FILL_CODE)
         kind = OP_FILL;
      else
         kind = OP_COPY;
   end

   logic unused_addr_lo;
   assign unused_addr_lo = ^cmd_addr[1:0];

endmodule

// File: rtl/pix_accel_seq.sv
module pix_accel_seq
   import pix_accel_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int PIX_AW    = 20,
   parameter int PIX_W     = 8,
   parameter int LEN_W     = 5,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  op_kind_e          kind,
   input  logic [PIX_AW-1:0] dst_in,
   input  logic [PIX_AW-1:0] src_in,
   input  logic [LEN_W-1:0]  len_in,
   input  logic [DATA_W-1:0] mask_in,
   input  logic [PIX_W-1:0]  colour,
   output logic              idle,
   output logic              mem_req,
   output logic              mem_we,
   output logic [PIX_AW-1:0] mem_addr,
   output logic [PIX_W-1:0]  mem_wdata,
   input  logic [PIX_W-1:0]  mem_rdata
);
   localparam int CNT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] STIP_LAST = CNT_W'(DATA_W - 1);

   seq_state_e        state_q;
   logic [PIX_AW-1:0] dst_q, src_q;
   logic [CNT_W-1:0]  cnt_q, len_q;
   logic [DATA_W-1:0] mask_q, mask_nxt;
   logic              cur_bit;
   logic              run_end;

   // mask scan direction variant
   generate
      if (MSB_FIRST) begin : g_msb
         assign cur_bit  = mask_q[DATA_W-1];
         assign mask_nxt = mask_q << 1;
      end else begin : g_lsb
         assign cur_bit  = mask_q[0];
         assign mask_nxt = mask_q >> 1;
      end
   endgenerate

   assign run_end = (cnt_q == len_q);
   assign idle    = (state_q == SQ_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         dst_q   <= '0;
         src_q   <= '0;
         cnt_q   <= '0;
         len_q   <= '0;
         mask_q  <= '0;
      end else begin
         unique case (state_q)
            SQ_IDLE: begin
               if (go) begin
                  dst_q  <= dst_in;
                  src_q  <= src_in;
                  len_q  <= CNT_W'(len_in);
                  mask_q <= mask_in;
                  cnt_q  <= '0;
                  unique case (kind)
                     OP_STIP: state_q <= SQ_STIP;
                     OP_FILL: state_q <= SQ_FILL;
                     default: state_q <= SQ_CRD;
                  endcase
               end
            end
            SQ_STIP: begin
               mask_q <= mask_nxt;
               dst_q  <= dst_q + 1'b1;
               cnt_q  <= cnt_q + 1'b1;
               if (cnt_q == STIP_LAST) state_q <= SQ_IDLE;
            end
            SQ_FILL: begin
               dst_q <= dst_q + 1'b1;
               cnt_q <= cnt_q + 1'b1;
               if (run_end) state_q <= SQ_IDLE;
            end
            SQ_CRD: begin
               src_q   <= src_q + 1'b1;
               state_q <= SQ_CWR;
            end
            SQ_CWR: begin
               dst_q   <= dst_q + 1'b1;
               cnt_q   <= cnt_q + 1'b1;
               state_q <= run_end ? SQ_IDLE : SQ_CRD;
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = dst_q;
      mem_wdata = colour;
      unique case (state_q)
         SQ_STIP: begin
            mem_req = cur_bit;
            mem_we  = cur_bit;
         end
         SQ_FILL: begin
            mem_req = 1'b1;
            mem_we  = 1'b1;
         end
         SQ_CRD: begin
            mem_req  = 1'b1;
            mem_addr = src_q;
         end
         SQ_CWR: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_wdata = mem_rdata;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/pix_accel_engine.sv
module pix_accel_engine
   import pix_accel_pkg::*;
#(
   parameter int APER_AW   = 23,
   parameter int DATA_W    = 32,
   parameter int PIX_AW    = 20,
   parameter int PIX_W     = 8,
   parameter int SRC_W     = 24,
   parameter int RUN_MAX   = 32,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   output logic               cmd_ready,
   input  logic               cmd_we,
   input  logic               cmd_sel,
   input  logic [APER_AW-1:0] cmd_addr,
   input  logic [DATA_W-1:0]  cmd_wdata,
   output logic [DATA_W-1:0]  cmd_rdata,
   output logic               busy,
   output logic               mem_req,
   output logic               mem_we,
   output logic [PIX_AW-1:0]  mem_addr,
   output logic [PIX_W-1:0]   mem_wdata,
   input  logic [PIX_W-1:0]   mem_rdata
);
   localparam int LEN_W = $clog2(RUN_MAX);

   // elaboration-time parameter checks
   generate
      if (APER_AW < PIX_AW + 3) begin : g_bad_aper
         $error("window offset too narrow for pixel address");
      end
      if (SRC_W < PIX_AW || SRC_W + LEN_W > DATA_W) begin : g_bad_src
         $error("source/length fields do not fit the data word");
      end
      if (RUN_MAX != (1 << LEN_W) || RUN_MAX > DATA_W) begin : g_bad_run
         $error("run length must be a power of two no larger than the mask");
      end
      if (PIX_W > DATA_W) begin : g_bad_pix
         $error("pixel wider than data word");
      end
   endgenerate

   logic              acc, go, idle;
   op_kind_e          kind;
   logic [DATA_W-1:0] colour, mask;
   logic [PIX_AW-1:0] dst;
   logic [SRC_W-1:0]  src;
   logic [LEN_W-1:0]  len_m1;

   assign acc       = cmd_valid && cmd_ready;
   assign cmd_ready = idle;
   assign busy      = !idle;
   assign cmd_rdata = '0;

   pix_accel_decode #(
      .APER_AW(APER_AW), .DATA_W(DATA_W), .PIX_AW(PIX_AW),
      .SRC_W(SRC_W), .LEN_W(LEN_W)
   ) u_dec (
      .clk(clk), .rst_n(rst_n), .acc(acc), .cmd_we(cmd_we),
      .cmd_sel(cmd_sel), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
      .colour(colour), .go(go), .kind(kind), .dst(dst), .src(src),
      .len_m1(len_m1), .mask(mask)
   );

   pix_accel_seq #(
      .DATA_W(DATA_W), .PIX_AW(PIX_AW), .PIX_W(PIX_W),
      .LEN_W(LEN_W), .MSB_FIRST(MSB_FIRST)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .go(go), .kind(kind),
      .dst_in(dst), .src_in(src[PIX_AW-1:0]), .len_in(len_m1),
      .mask_in(mask), .colour(colour[PIX_W-1:0]), .idle(idle),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   logic unused_hi;
   assign unused_hi = ^{colour[DATA_W-1:PIX_W], src[SRC_W-1:PIX_AW]};

endmodule

// File: rtl/pix_accel_engine_chk.sv
module pix_accel_engine_chk #(
   parameter int APER_AW = 23,
   parameter int DATA_W  = 32,
   parameter int PIX_AW  = 20,
   parameter int PIX_W   = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cmd_valid,
   input logic               cmd_ready,
   input logic               cmd_we,
   input logic               cmd_sel,
   input logic [APER_AW-1:0] cmd_addr,
   input logic               busy,
   input logic               mem_req,
   input logic               mem_we,
   input logic [PIX_AW-1:0]  mem_addr,
   input logic [PIX_W-1:0]   mem_wdata
);
   localparam int SC_W = $clog2(DATA_W) + 1;

   logic            stip_go;
   logic [SC_W-1:0] stip_left;

   assign stip_go = cmd_valid && cmd_ready && cmd_we && cmd_addr[2] && !cmd_sel;

   always_ff @(posedge clk) begin
      if (!rst_n)
         stip_left <= '0;
      else if (stip_go)
         stip_left <= SC_W'(DATA_W);
      else if (stip_left != '0)
         stip_left <= stip_left - 1'b1;
   end

   // R8
   ready_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !cmd_ready);

   // R9
   mem_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req);

   // R5
   copy_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |=> (mem_req && mem_we));

   // R9
   run_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && $past(mem_req && mem_we)) |->
         (mem_addr == $past(mem_addr) + 1'b1));

   // R1
   run_colour_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && $past(mem_req && mem_we)) |->
         (mem_wdata == $past(mem_wdata)));

   // R4
   stip_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stip_left != '0) |-> busy);

   // R4
   stip_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stip_left == SC_W'(1)) |=> !busy);

endmodule

bind pix_accel_engine pix_accel_engine_chk #(
   .APER_AW(APER_AW), .DATA_W(DATA_W), .PIX_AW(PIX_AW), .PIX_W(PIX_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
   .cmd_we(cmd_we), .cmd_sel(cmd_sel), .cmd_addr(cmd_addr), .busy(busy),
   .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
   .mem_wdata(mem_wdata)
);

// File: tb/tb_pix_accel_engine.sv
`timescale 1ns/1ps
module tb_pix_accel_engine;
   localparam int MEM_N = 4096;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0, cmd_we = 1'b0, cmd_sel = 1'b0;
   logic [22:0] cmd_addr = '0;
   logic [31:0] cmd_wdata = '0;
   logic        cmd_ready, busy, mem_req, mem_we;
   logic [31:0] cmd_rdata;
   logic [19:0] mem_addr;
   logic [7:0]  mem_wdata, mem_rdata;

   logic [7:0] mem  [0:MEM_N-1];
   logic [7:0] refm [0:MEM_N-1];
   logic [7:0] col_ref;
   int total = 0, bad = 0, wr_cnt = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pix_accel_engine dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_we(cmd_we), .cmd_sel(cmd_sel), .cmd_addr(cmd_addr),
      .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata), .busy(busy),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   // single-port memory model, one-cycle read latency
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < MEM_N; i++) mem[i] <= 8'(i * 7 + 3);
         mem_rdata <= '0;
      end else if (mem_req) begin
         if (mem_we) begin
            mem[mem_addr[11:0]] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
         end else begin
            mem_rdata <= mem[mem_addr[11:0]];
         end
      end
   end

   task automatic chk(bit ok, string req, string what, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic issue(bit sel, bit we, logic [22:0] a, logic [31:0] d);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_sel = sel; cmd_we = we; cmd_addr = a; cmd_wdata = d;
      while (!cmd_ready) @(negedge clk);
      @(posedge clk);
      #1 cmd_valid = 1'b0;
   endtask

   task automatic wait_idle(output int cyc);
      cyc = 0;
      @(negedge clk);
      while (busy) begin
         cyc++;
         @(negedge clk);
      end
   endtask

   function automatic int popc(logic [31:0] m);
      int n = 0;
      for (int i = 0; i < 32; i++) n += int'(m[i]);
      return n;
   endfunction

   function automatic void ref_stip(int dst, logic [31:0] m);
      for (int i = 0; i < 32; i++)
         if (m[31-i]) refm[dst+i] = col_ref;
   endfunction

   function automatic void ref_blit(int dst, logic [31:0] d);
      int len = int'(d[28:24]) + 1;
      for (int i = 0; i < len; i++)
         if (d[23:0] == 24'hFFFFFF) refm[dst+i] = col_ref;
         else refm[dst+i] = refm[int'(d[23:0]) + i];
   endfunction

   task automatic cmp_mem(string req);
      int miss = 0, first = -1;
      for (int i = 0; i < MEM_N; i++)
         if (mem[i] !== refm[i]) begin
            miss++;
            if (first < 0) first = i;
         end
      if (first < 0) first = 0;
      chk(miss == 0, req, $sformatf("memory image, first bad pixel %0d", first),
          int'(mem[first]), int'(refm[first]));
   endtask

   function automatic logic [22:0] go_addr(int dst, logic [1:0] lo);
      return {dst[19:0], 1'b1, lo};
   endfunction

   task automatic set_colour(logic [31:0] c);
      issue(1'b0, 1'b1, 23'h0, c);
      col_ref = c[7:0];
   endtask

   task automatic do_stip(int dst, logic [31:0] m, string req);
      int cyc, w0;
      w0 = wr_cnt;
      issue(1'b0, 1'b1, go_addr(dst, 2'b11), m);
      ref_stip(dst, m);
      wait_idle(cyc);
      chk(cyc == 32, "R4", "stipple busy cycles", cyc, 32);
      chk(wr_cnt - w0 == popc(m), "R3", "stipple write count", wr_cnt - w0, popc(m));
      cmp_mem(req);
   endtask

   task automatic do_blit(int dst, logic [31:0] d, string req);
      int cyc, w0, len, expc;
      len = int'(d[28:24]) + 1;
      expc = (d[23:0] == 24'hFFFFFF) ? len : 2 * len;
      w0 = wr_cnt;
      issue(1'b1, 1'b1, go_addr(dst, 2'b00), d);
      ref_blit(dst, d);
      wait_idle(cyc);
      chk(cyc == expc, req, "blit busy cycles", cyc, expc);
      chk(wr_cnt - w0 == len, req, "blit write count", wr_cnt - w0, len);
      cmp_mem(req);
   endtask

   initial begin
      int cyc;
      void'($urandom(32'd1234));
      for (int i = 0; i < MEM_N; i++) refm[i] = 8'(i * 7 + 3);
      col_ref = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state: R8 R9
      chk(cmd_ready === 1'b1 && busy === 1'b0, "R8", "ready/busy after reset",
          int'({cmd_ready, busy}), 2);
      chk(mem_req === 1'b0, "R9", "memory idle after reset", int'(mem_req), 0);

      // R1 colour load, no memory effect; R2 address bits 1:0 ignored
      set_colour(32'h1234_56AB);
      cmp_mem("R1");
      do_stip(100, 32'h8000_0001, "R2");
      do_stip(200, 32'h0000_0000, "R3");
      do_stip(300, 32'hFFFF_FFFF, "R3");
      do_stip(400, 32'hA5C3_0F18, "R3");

      // R6 fill: length 1 and 32, upper data bits set to show they are ignored
      set_colour(32'hFFFF_FF3C);
      do_blit(600, {3'b111, 5'd0, 24'hFFFFFF}, "R6");
      do_blit(700, {3'b000, 5'd31, 24'hFFFFFF}, "R6");

      // R5 copies: disjoint, then overlapping forward (ascending smear)
      do_blit(1000, {3'b101, 5'd31, 24'd2000}, "R5");
      do_blit(1501, {3'b000, 5'd15, 24'd1500}, "R5");
      do_blit(1700, {3'b000, 5'd0, 24'd3}, "R5");

      // R7 read returns zero, leaves memory and colour alone
      @(negedge clk);
      cmd_valid = 1'b1; cmd_we = 1'b0; cmd_sel = 1'b1;
      cmd_addr = go_addr(800, 2'b00); cmd_wdata = 32'h0000_0077;
      #1 chk(cmd_rdata == 32'h0, "R7", "read data", int'(cmd_rdata), 0);
      @(posedge clk);
      #1 cmd_valid = 1'b0;
      wait_idle(cyc);
      chk(cyc == 0, "R7", "read started no operation", cyc, 0);
      cmp_mem("R7");
      do_blit(820, {3'b000, 5'd3, 24'hFFFFFF}, "R7");

      // R8 stall: colour load presented during a fill waits for it
      issue(1'b1, 1'b1, go_addr(900, 2'b00), {8'd31, 24'hFFFFFF});
      ref_blit(900, {8'd31, 24'hFFFFFF});
      chk(busy === 1'b1 && cmd_ready === 1'b0, "R8", "ready low while busy",
          int'({busy, cmd_ready}), 2);
      set_colour(32'h0000_00E1);
      chk(busy === 1'b0, "R8", "colour load held until idle", int'(busy), 0);
      issue(1'b0, 1'b1, go_addr(950, 2'b00), 32'hF000_000F);
      ref_stip(950, 32'hF000_000F);
      wait_idle(cyc);
      cmp_mem("R8");

      // constrained random mix
      for (int n = 0; n < 40; n++) begin
         int kind = $urandom_range(0, 3);
         int dst  = $urandom_range(0, 4000);
         logic [31:0] d = $urandom;
         if (kind == 0) begin
            do_stip(dst, d, "R3");
         end else if (kind == 1) begin
            d[23:0] = 24'hFFFFFF;
            do_blit(dst, d, "R6");
         end else if (kind == 2) begin
            d[23:0] = 24'($urandom_range(0, 4000));
            do_blit(dst, d, "R5");
         end else begin
            set_colour($urandom);
         end
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule